// File: doc/BRIEF.md
# Row-Strobed Dot Matrix Scanner

This block drives a small array of 5×5 dot characters by lighting one row at a time. A multiplex tick, taken either from an internal clock divider or from an external tick input, advances a scan counter. The counter splits one full refresh into one slot per row, and each slot is a fixed number of ticks long. While a slot is active, the block asks the dot RAM for that row and receives the column bits of every character at once. It passes them to the column outputs and raises a one-hot row enable.

Brightness is set by how long the strobe stays on within each slot. The slot is divided into sixteen equal phases, and a 3-bit code chooses how many leading phases are lit. Lamp test lights every dot at a fixed mid level. Blank darkens the outputs while the scan keeps running. Power down darkens the outputs and also freezes the scan counter and the internal divider.

The default build has five rows, ten characters and 64-tick slots. That gives a 320-tick frame.

Top module: `dot_scanner`

## Requirements
- R1: While reset is low, and right after it rises, the scan sits at row 0, slot position 0. With brightness code 0 and no override active, `row_en` is 1 (row 0) and `col_out` equals `ram_rd_data`. Reset is asynchronous and also clears the internal divider.
- R2: Each accepted multiplex tick advances the slot position by one. After SLOT_LEN ticks the position wraps to 0 and the row advances. After row ROWS-1 the row returns to 0, so one frame is ROWS×SLOT_LEN ticks. With no accepted tick, the position and the row hold.
- R3: `ram_rd_row` always equals the active row. `row_en` is zero or one-hot, with bit r meaning row r. When the strobe is on, bit c×COLS+k of `col_out` equals the same bit of `ram_rd_data` (character c, column k).
- R4: The phase is the slot position × 16 / SLOT_LEN. The strobe is on while the phase is below 15, 8, 6, 4, 3, 2 or 1 for `brt_code` 0 to 6. Code 7 keeps the strobe off. When the strobe is off, `row_en` and `col_out` are all zero.
- R5: While `lamp_test` is high, the strobe duty is 8/16 whatever `brt_code` holds, and `col_out` is all ones while the strobe is on. When lamp test drops, RAM data returns on the next sample.
- R6: While `power_down` is high, all outputs are low, ticks are not accepted, and the internal divider holds. When it drops, the scan resumes from the position where it stopped.
- R7: While `blank` is high, all outputs are low but ticks are still accepted.
- R8: With `clk_sel` high, one tick is accepted every INT_DIV clocks, counted from reset, and `ext_tick` is ignored. With `clk_sel` low, a tick is accepted in each clock cycle where `ext_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 1 | 1: internal divider, 0: external tick |
| ext_tick | input | 1 | External multiplex tick, one clock wide per tick |
| brt_code | input | 3 | Brightness code, 0 brightest, 7 off |
| lamp_test | input | 1 | Light all dots at the 8/16 duty level |
| power_down | input | 1 | Dark outputs, frozen scan |
| blank | input | 1 | Dark outputs, scan keeps running |
| ram_rd_row | output | $clog2(ROWS) | Row being read from the dot RAM |
| ram_rd_data | input | CHARS*COLS | Column bits of that row for all characters |
| row_en | output | ROWS | One-hot row strobe |
| col_out | output | CHARS*COLS | Column drive |

## Verification
The bench builds the block with two characters, 16-tick slots and an internal divide of 3. With these values the phase equals the slot position, and a whole 80-tick frame takes only a few hundred cycles. That makes it cheap to sweep every brightness code, including code 7, across every slot position of every row. The internal divider, a power-down window and a reset in the middle of a scan are each checked cycle by cycle against a tick count that the bench keeps on its own.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int PHASES      = 16;
  localparam int LAMP_LEVEL  = 8;

  // number of lit sixteenths per brightness code
  function automatic logic [4:0] lit_phases(input logic [2:0] code);
    case (code)
      3'd0:    lit_phases = 5'd15;
      3'd1:    lit_phases = 5'd8;
      3'd2:    lit_phases = 5'd6;
      3'd3:    lit_phases = 5'd4;
      3'd4:    lit_phases = 5'd3;
      3'd5:    lit_phases = 5'd2;
      3'd6:    lit_phases = 5'd1;
      default: lit_phases = 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/mux_tick_gen.sv
module mux_tick_gen #(
  parameter int INT_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clk_sel,
  input  logic ext_tick,
  output logic mux_tick
);
  localparam int DIV_W = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(INT_DIV - 1);

  logic [DIV_W-1:0] div_cnt;
  logic             int_tick;

  assign int_tick = run && (div_cnt == DIV_LAST);
  assign mux_tick = run && (clk_sel ? int_tick : ext_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_cnt <= '0;
    else if (run) begin
      if (div_cnt == DIV_LAST) div_cnt <= '0;
      else                     div_cnt <= div_cnt + 1'b1;
    end
  end

  // R6
  frozen_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mux_tick);
  // R6
  frozen_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(div_cnt));
  // R8
  ext_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_sel && !ext_tick) |-> !mux_tick);
endmodule

// File: rtl/scan_counter.sv
module scan_counter #(
  parameter int ROWS     = 5,
  parameter int SLOT_LEN = 64,
  parameter int SLOT_W   = $clog2(SLOT_LEN),
  parameter int ROW_W    = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [SLOT_W-1:0] slot_cnt,
  output logic [ROW_W-1:0]  row_idx,
  output logic              slot_wrap
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_LEN - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(ROWS - 1);

  assign slot_wrap = step && (slot_cnt == SLOT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_cnt <= '0;
      row_idx  <= '0;
    end else if (step) begin
      slot_cnt <= slot_cnt + 1'b1;
      if (slot_wrap) begin
        slot_cnt <= '0;
        row_idx  <= (row_idx == ROW_LAST) ? '0 : row_idx + 1'b1;
      end
    end
  end

  // R2
  slot_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && slot_cnt != SLOT_LAST) |=> (slot_cnt == $past(slot_cnt) + 1'b1) && $stable(row_idx));
  // R2
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && slot_cnt == SLOT_LAST && row_idx == ROW_LAST) |=> (slot_cnt == '0) && (row_idx == '0));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(slot_cnt) && $stable(row_idx));
  // R3
  row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_idx <= ROW_LAST);
endmodule

// File: rtl/strobe_gate.sv
module strobe_gate
  import scan_pkg::*;
#(
  parameter int ROWS   = 5,
  parameter int COLS   = 5,
  parameter int CHARS  = 10,
  parameter int SLOT_W = 6,
  parameter int ROW_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SLOT_W-1:0]      slot_cnt,
  input  logic [ROW_W-1:0]       row_idx,
  input  logic [2:0]             brt_code,
  input  logic                   lamp_test,
  input  logic                   power_down,
  input  logic                   blank,
  input  logic [CHARS*COLS-1:0]  ram_rd_data,
  output logic [ROWS-1:0]        row_en,
  output logic [CHARS*COLS-1:0]  col_out
);
  localparam int PH_W = $clog2(PHASES);

  logic [PH_W-1:0] phase;
  logic [4:0]      level;
  logic            dark;
  logic            strobe_on;

  assign phase     = slot_cnt[SLOT_W-1 -: PH_W];
  assign level     = lamp_test ? 5'(LAMP_LEVEL) : lit_phases(brt_code);
  assign dark      = blank || power_down;
  assign strobe_on = !dark && ({1'b0, phase} < level);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_en[r] = strobe_on && (row_idx == ROW_W'(r));
  end

  for (genvar c = 0; c < CHARS; c++) begin : g_char
    assign col_out[c*COLS +: COLS] =
      !strobe_on ? '0 : (lamp_test ? {COLS{1'b1}} : ram_rd_data[c*COLS +: COLS]);
  end

  // R3
  row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_en));
  // R3
  cols_need_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_en == '0) |-> (col_out == '0));
  // R6
  dark_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dark |-> (row_en == '0) && (col_out == '0));
  // R5
  lamp_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_test && row_en != '0) |-> (&col_out));
endmodule

// File: rtl/dot_scanner.sv
module dot_scanner #(
  parameter int ROWS     = 5,
  parameter int COLS     = 5,
  parameter int CHARS    = 10,
  parameter int SLOT_LEN = 64,
  parameter int INT_DIV  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clk_sel,
  input  logic                      ext_tick,
  input  logic [2:0]                brt_code,
  input  logic                      lamp_test,
  input  logic                      power_down,
  input  logic                      blank,
  output logic [$clog2(ROWS)-1:0]   ram_rd_row,
  input  logic [CHARS*COLS-1:0]     ram_rd_data,
  output logic [ROWS-1:0]           row_en,
  output logic [CHARS*COLS-1:0]     col_out
);
  localparam int SLOT_W = $clog2(SLOT_LEN);
  localparam int ROW_W  = $clog2(ROWS);

  logic              mux_tick;
  logic              slot_wrap;
  logic [SLOT_W-1:0] slot_cnt;
  logic [ROW_W-1:0]  row_idx;

  mux_tick_gen #(.INT_DIV(INT_DIV)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (!power_down),
    .clk_sel  (clk_sel),
    .ext_tick (ext_tick),
    .mux_tick (mux_tick)
  );

  scan_counter #(.ROWS(ROWS), .SLOT_LEN(SLOT_LEN), .SLOT_W(SLOT_W), .ROW_W(ROW_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (mux_tick),
    .slot_cnt  (slot_cnt),
    .row_idx   (row_idx),
    .slot_wrap (slot_wrap)
  );

  strobe_gate #(.ROWS(ROWS), .COLS(COLS), .CHARS(CHARS), .SLOT_W(SLOT_W), .ROW_W(ROW_W)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_cnt    (slot_cnt),
    .row_idx     (row_idx),
    .brt_code    (brt_code),
    .lamp_test   (lamp_test),
    .power_down  (power_down),
    .blank       (blank),
    .ram_rd_data (ram_rd_data),
    .row_en      (row_en),
    .col_out     (col_out)
  );

  assign ram_rd_row = row_idx;

  // R2
  row_step_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_wrap |=> $stable(ram_rd_row));
  // R6
  pd_holds_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |=> $stable(ram_rd_row));
endmodule

// File: tb/tb_dot_scanner.sv
module tb_dot_scanner;
  localparam int ROWS = 5, COLS = 5, CHARS = 2, SLOT = 16, DIV = 3;
  localparam int W = CHARS * COLS;

  logic clk = 1'b0;
  logic rst_n = 1'b0, clk_sel = 1'b0, ext_tick = 1'b0;
  logic [2:0] brt_code = 3'd0;
  logic lamp_test = 1'b0, power_down = 1'b0, blank = 1'b0;
  logic [2:0] ram_rd_row;
  logic [W-1:0] ram_rd_data;
  logic [ROWS-1:0] row_en;
  logic [W-1:0] col_out;
  logic [W-1:0] mem [ROWS];

  int compared = 0, mismatched = 0, n = 0;
  int duty_tab [8] = '{15, 8, 6, 4, 3, 2, 1, 0};

  always #4 clk = ~clk;

  assign ram_rd_data = mem[ram_rd_row];

  dot_scanner #(.ROWS(ROWS), .COLS(COLS), .CHARS(CHARS), .SLOT_LEN(SLOT), .INT_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_tick(ext_tick), .brt_code(brt_code),
    .lamp_test(lamp_test), .power_down(power_down), .blank(blank), .ram_rd_row(ram_rd_row),
    .ram_rd_data(ram_rd_data), .row_en(row_en), .col_out(col_out));

  task automatic fill_mem(input int seed);
    for (int r = 0; r < ROWS; r++) mem[r] = W'((r + 1) * 37 + seed * 91) ^ W'(seed << r);
  endtask

  task automatic check(input string req);
    int slot = n % SLOT;
    int row  = (n / SLOT) % ROWS;
    int lvl  = lamp_test ? 8 : duty_tab[brt_code];
    logic on = !blank && !power_down && (slot < lvl);
    logic [ROWS-1:0] er = on ? ROWS'(1 << row) : '0;
    logic [W-1:0] ec = !on ? '0 : (lamp_test ? {W{1'b1}} : mem[row]);
    compared++;
    if (row_en !== er || col_out !== ec || ram_rd_row !== 3'(row)) begin
      mismatched++;
      $display("FAIL %s n=%0d: row_en=%b col=%b rd_row=%0d expected row_en=%b col=%b rd_row=%0d",
               req, n, row_en, col_out, ram_rd_row, er, ec, row);
    end
  endtask

  task automatic tick(input string req);
    ext_tick = 1'b1;
    @(negedge clk);
    ext_tick = 1'b0;
    if (!power_down) n++;
    check(req);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    fill_mem(1);
    #20;
    check("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // R2 R3 R4: every code across a full frame
    for (int code = 0; code < 8; code++) begin
      brt_code = 3'(code);
      fill_mem(code + 2);
      for (int t = 0; t < ROWS * SLOT; t++) tick("R2/R3/R4 sweep");
    end

    // R5 lamp test overrides code
    brt_code = 3'd5;
    lamp_test = 1'b1;
    for (int t = 0; t < ROWS * SLOT; t++) tick("R5 lamp");
    lamp_test = 1'b0;
    brt_code = 3'd0;
    #1 check("R5 data returns");

    // R7 blank keeps scanning
    blank = 1'b1;
    for (int t = 0; t < 23; t++) tick("R7 blank");
    blank = 1'b0;
    #1 check("R7 after blank");

    // R6 power down freezes
    power_down = 1'b1;
    for (int t = 0; t < 11; t++) tick("R6 frozen");
    power_down = 1'b0;
    #1 check("R6 resume");
    for (int t = 0; t < 5; t++) tick("R6 resume steps");

    // R8 external mode with no tick
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      check("R8 ext idle");
    end

    // R1 reset mid-scan, then R8 internal divider ignoring ext_tick
    rst_n = 1'b0;
    n = 0;
    #1 check("R1 mid-scan reset");
    clk_sel = 1'b1;
    ext_tick = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    begin
      int active = 0;
      for (int k = 1; k <= 300; k++) begin
        power_down = (k > 150 && k <= 161);
        @(negedge clk);
        if (!power_down) active++;
        n = active / DIV;
        check(power_down ? "R6 internal frozen" : "R8 internal");
      end
      power_down = 1'b0;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule